// File: doc/BRIEF.md
# Debug Mailbox Handshake

This block holds two one-word mailboxes that pass data between an on-chip debug handler and an external debugger. The outbound slot carries words from the handler to the debugger. The inbound slot carries words from the debugger to the handler. Three flags track the handshake: the outbound slot is holding a word, the inbound slot is holding a word, and a sticky flag records that an inbound word was lost.

The handler reaches the block through a plain register port. It has a write strobe, a read strobe and a two-bit register select, and read data is returned in the same cycle. The debugger side is word-level. A read strobe consumes the outbound word, and a write strobe delivers an inbound word. The flags are also driven out as levels so the debugger can poll them.

Each slot is a two-state machine, EMPTY and FULL. The loss flag is a two-state machine, CLEAR and SET. The outbound slot moves EMPTY→FULL on an accepted handler write and FULL→EMPTY on a debugger read. The inbound slot moves EMPTY→FULL on a debugger write and FULL→EMPTY on a handler read that is not met by a debugger write in the same cycle. A debugger write in FULL keeps the slot FULL. The loss flag moves CLEAR→SET on a debugger write while the inbound slot is FULL, and SET→CLEAR on a handler clear command.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset all three flags are 0, both data words are 0, and a read of the control register returns 0.
- R2: A handler write to select 1 (outbound) while the outbound flag is 0 stores the write data, which appears on `dbg_tx_word` after the clock edge, and sets the outbound flag.
- R3: A handler write to select 1 while the outbound flag is 1 is ignored: `dbg_tx_word` keeps its value and the flag stays 1.
- R4: The inbound flag has no influence on whether an outbound write is accepted. A write to select 1 with the outbound flag 0 is stored even when the inbound flag is 1.
- R5: A debugger read strobe (`dbg_tx_rd`) while the outbound flag is 1 clears the flag.
- R6: A debugger write (`dbg_rx_wr`) stores `dbg_rx_word` and sets the inbound flag. A handler read of select 2 (inbound) returns the stored word and clears the inbound flag.
- R7: A debugger write while the inbound flag is 1 replaces the pending word and sets the loss flag.
- R8: When a debugger write and a handler read of select 2 fall in the same cycle, the handler receives the new word in that cycle and the inbound flag stays 1. If a word was pending, the loss flag is set.
- R9: The loss flag is sticky. Only a handler write to select 0 with data bit 2 = 1 clears it, and writing bit 2 = 0 leaves it set. If a clear and a new loss fall in the same cycle, the flag ends up set.
- R10: A read of select 0 returns bit 0 = outbound flag, bit 1 = inbound flag, bit 2 = loss flag, and all other bits 0. Select 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hnd_we | input | 1 | Handler write strobe |
| hnd_re | input | 1 | Handler read strobe |
| hnd_sel | input | 2 | Register select: 0 control, 1 outbound, 2 inbound, 3 unused |
| hnd_wdata | input | DATA_W | Handler write data |
| hnd_rdata | output | DATA_W | Handler read data, same cycle |
| dbg_tx_rd | input | 1 | Debugger consumes the outbound word |
| dbg_tx_word | output | DATA_W | Outbound word |
| dbg_rx_wr | input | 1 | Debugger delivers an inbound word |
| dbg_rx_word | input | DATA_W | Inbound word from the debugger |
| flag_tx_full | output | 1 | Outbound slot holds an unread word |
| flag_rx_full | output | 1 | Inbound slot holds an unread word |
| flag_lost | output | 1 | Sticky inbound loss flag |

## Verification
The outbound path is driven in four situations:
- a write into an empty slot, which shows that the word is captured;
- a write into a full slot, which shows that unread data is protected;
- a write with the inbound flag raised, which shows that the two flags are independent;
- a debugger read, which shows that the slot is released.

The inbound path is driven with:
- a lone write followed by a read, the normal handshake;
- a write onto a pending word, which shows the loss detection;
- a write and a read in the same cycle, once with a pending word and once without, which separates the bypass of the new word from the loss decision.

The loss flag is then driven with a write of 0, a write of 1, and a clear that meets a new loss in the same cycle. This shows that only the clear command resets it and that a new loss wins over a clear.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_TX   = 2'd1,
        SEL_RX   = 2'd2,
        SEL_NONE = 2'd3
    } mbx_sel_e;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

    typedef enum logic {
        LOSS_CLEAR = 1'b0,
        LOSS_SET   = 1'b1
    } loss_state_e;

    localparam int unsigned BIT_TXF  = 0;
    localparam int unsigned BIT_RXF  = 1;
    localparam int unsigned BIT_LOST = 2;

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              hnd_we,
    input  logic              hnd_re,
    input  logic [1:0]        hnd_sel,
    input  logic [DATA_W-1:0] hnd_wdata,
    output logic              tx_wr,
    output logic              rx_rd,
    output logic              loss_clr
);

    mbx_sel_e sel;

    always_comb begin
        sel      = mbx_sel_e'(hnd_sel);
        tx_wr    = 1'b0;
        rx_rd    = 1'b0;
        loss_clr = 1'b0;
        unique case (sel)
            SEL_CTRL: loss_clr = hnd_we && hnd_wdata[BIT_LOST];
            SEL_TX:   tx_wr    = hnd_we;
            SEL_RX:   rx_rd    = hnd_re;
            SEL_NONE: ;
        endcase
    end

endmodule

// File: rtl/mbx_tx_slot.sv
module mbx_tx_slot
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd,
    output logic [DATA_W-1:0] word,
    output logic              full
);

    slot_state_e       state_q, state_d;
    logic [DATA_W-1:0] data_q, data_d;

    // Next-state: EMPTY->FULL on write, FULL->EMPTY on debugger read.
    always_comb begin
        state_d = state_q;
        data_d  = data_q;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (wr) begin
                    state_d = SLOT_FULL;
                    data_d  = wr_data;
                end
            end
            SLOT_FULL: begin
                if (rd) state_d = SLOT_EMPTY;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            data_q  <= data_d;
        end
    end

    always_comb begin
        full = (state_q == SLOT_FULL);
        word = data_q;
    end

endmodule

// File: rtl/mbx_rx_slot.sv
module mbx_rx_slot
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd,
    input  logic              loss_clr,
    output logic [DATA_W-1:0] rd_word,
    output logic              full,
    output logic              lost
);

    slot_state_e       state_q, state_d;
    loss_state_e       loss_q, loss_d;
    logic [DATA_W-1:0] data_q, data_d;

    // Slot: a write always lands; a read empties only when unopposed.
    always_comb begin
        state_d = state_q;
        data_d  = wr ? wr_data : data_q;
        unique case (state_q)
            SLOT_EMPTY: if (wr) state_d = SLOT_FULL;
            SLOT_FULL:  if (!wr && rd) state_d = SLOT_EMPTY;
        endcase
    end

    // Loss flag: a write onto a pending word sets it and wins over a clear.
    always_comb begin
        loss_d = loss_q;
        unique case (loss_q)
            LOSS_CLEAR: if (wr && state_q == SLOT_FULL) loss_d = LOSS_SET;
            LOSS_SET:   if (loss_clr && !(wr && state_q == SLOT_FULL))
                            loss_d = LOSS_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
            loss_q  <= LOSS_CLEAR;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            loss_q  <= loss_d;
            data_q  <= data_d;
        end
    end

    always_comb begin
        full    = (state_q == SLOT_FULL);
        lost    = (loss_q == LOSS_SET);
        rd_word = wr ? wr_data : data_q;
    end

endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hnd_we,
    input  logic              hnd_re,
    input  logic [1:0]        hnd_sel,
    input  logic [DATA_W-1:0] hnd_wdata,
    output logic [DATA_W-1:0] hnd_rdata,
    input  logic              dbg_tx_rd,
    output logic [DATA_W-1:0] dbg_tx_word,
    input  logic              dbg_rx_wr,
    input  logic [DATA_W-1:0] dbg_rx_word,
    output logic              flag_tx_full,
    output logic              flag_rx_full,
    output logic              flag_lost
);

    logic              tx_wr, rx_rd, loss_clr;
    logic [DATA_W-1:0] rx_rd_word;
    logic [DATA_W-1:0] ctrl_word;

    mbx_decode #(.DATA_W(DATA_W)) u_dec (
        .hnd_we    (hnd_we),
        .hnd_re    (hnd_re),
        .hnd_sel   (hnd_sel),
        .hnd_wdata (hnd_wdata),
        .tx_wr     (tx_wr),
        .rx_rd     (rx_rd),
        .loss_clr  (loss_clr)
    );

    mbx_tx_slot #(.DATA_W(DATA_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (tx_wr),
        .wr_data (hnd_wdata),
        .rd      (dbg_tx_rd),
        .word    (dbg_tx_word),
        .full    (flag_tx_full)
    );

    mbx_rx_slot #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (dbg_rx_wr),
        .wr_data  (dbg_rx_word),
        .rd       (rx_rd),
        .loss_clr (loss_clr),
        .rd_word  (rx_rd_word),
        .full     (flag_rx_full),
        .lost     (flag_lost)
    );

    always_comb begin
        ctrl_word           = '0;
        ctrl_word[BIT_TXF]  = flag_tx_full;
        ctrl_word[BIT_RXF]  = flag_rx_full;
        ctrl_word[BIT_LOST] = flag_lost;
    end

    always_comb begin
        unique case (mbx_sel_e'(hnd_sel))
            SEL_CTRL: hnd_rdata = ctrl_word;
            SEL_TX:   hnd_rdata = dbg_tx_word;
            SEL_RX:   hnd_rdata = rx_rd_word;
            SEL_NONE: hnd_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hnd_we,
    input logic              hnd_re,
    input logic [1:0]        hnd_sel,
    input logic [DATA_W-1:0] hnd_wdata,
    input logic [DATA_W-1:0] hnd_rdata,
    input logic              dbg_tx_rd,
    input logic [DATA_W-1:0] dbg_tx_word,
    input logic              dbg_rx_wr,
    input logic [DATA_W-1:0] dbg_rx_word,
    input logic              flag_tx_full,
    input logic              flag_rx_full,
    input logic              flag_lost
);

    logic tx_wr_c, rx_rd_c, clr_c;
    assign tx_wr_c = hnd_we && hnd_sel == 2'd1;
    assign rx_rd_c = hnd_re && hnd_sel == 2'd2;
    assign clr_c   = hnd_we && hnd_sel == 2'd0 && hnd_wdata[2];

    p_tx_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flag_tx_full && tx_wr_c |=> $stable(dbg_tx_word));

    p_tx_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_tx_full && tx_wr_c |=> flag_tx_full && dbg_tx_word == $past(hnd_wdata));

    p_tx_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_tx_full && dbg_tx_rd |=> !flag_tx_full);

    p_rx_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_rx_wr |=> flag_rx_full);

    p_loss_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rx_full && dbg_rx_wr |=> flag_lost);

    p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_rx_wr && rx_rd_c |-> hnd_rdata == dbg_rx_word);

    p_loss_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_lost && !clr_c |=> flag_lost);

endmodule

bind dbg_mailbox mbx_checker #(.DATA_W(DATA_W)) u_mbx_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hnd_we       (hnd_we),
    .hnd_re       (hnd_re),
    .hnd_sel      (hnd_sel),
    .hnd_wdata    (hnd_wdata),
    .hnd_rdata    (hnd_rdata),
    .dbg_tx_rd    (dbg_tx_rd),
    .dbg_tx_word  (dbg_tx_word),
    .dbg_rx_wr    (dbg_rx_wr),
    .dbg_rx_word  (dbg_rx_word),
    .flag_tx_full (flag_tx_full),
    .flag_rx_full (flag_rx_full),
    .flag_lost    (flag_lost)
);

// File: tb/test_dbg_mailbox.sv
module test_dbg_mailbox;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hnd_we = 1'b0, hnd_re = 1'b0;
    logic [1:0]    hnd_sel = 2'd0;
    logic [DW-1:0] hnd_wdata = '0;
    logic [DW-1:0] hnd_rdata;
    logic          dbg_tx_rd = 1'b0;
    logic [DW-1:0] dbg_tx_word;
    logic          dbg_rx_wr = 1'b0;
    logic [DW-1:0] dbg_rx_word = '0;
    logic          flag_tx_full, flag_rx_full, flag_lost;

    always #2.5 clk = ~clk;

    dbg_mailbox #(.DATA_W(DW)) i_dbg_mailbox (.*);

    typedef struct {
        int          what;   // 0 tx word, 1 tx flag, 2 rx flag, 3 loss, 4 rdata
        logic [DW-1:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;

    task automatic expect_val(int what, logic [DW-1:0] exp, string req);
        item_t it;
        it.what = what; it.exp = exp; it.req = req;
        q.push_back(it);
        #0.1;
    endtask

    // Monitor: pops expectations and compares against the live outputs.
    initial begin
        forever begin
            item_t it;
            logic [DW-1:0] act;
            wait (q.size() > 0);
            it = q.pop_front();
            case (it.what)
                0: act = dbg_tx_word;
                1: act = {{(DW-1){1'b0}}, flag_tx_full};
                2: act = {{(DW-1){1'b0}}, flag_rx_full};
                3: act = {{(DW-1){1'b0}}, flag_lost};
                default: act = hnd_rdata;
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s item %0d: actual %h expected %h", it.req, it.what, act, it.exp);
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        hnd_we = 0; hnd_re = 0; dbg_tx_rd = 0; dbg_rx_wr = 0;
    endtask

    task automatic hwrite(logic [1:0] sel, logic [DW-1:0] d);
        @(negedge clk);
        hnd_we = 1; hnd_sel = sel; hnd_wdata = d;
        idle();
    endtask

    task automatic dwrite(logic [DW-1:0] d);
        @(negedge clk);
        dbg_rx_wr = 1; dbg_rx_word = d;
        idle();
    endtask

    task automatic dread();
        @(negedge clk);
        dbg_tx_rd = 1;
        idle();
    endtask

    // Combinational read: check data in the same cycle, then let the edge pass.
    task automatic hread(logic [1:0] sel, logic [DW-1:0] exp, string req);
        @(negedge clk);
        hnd_re = 1; hnd_sel = sel;
        #1 expect_val(4, exp, req);
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        expect_val(0, 0, "R1"); expect_val(1, 0, "R1");
        expect_val(2, 0, "R1"); expect_val(3, 0, "R1");
        hread(2'd0, 0, "R1");

        // R2 accept into empty slot
        hwrite(2'd1, 32'hA5A5_0001);
        expect_val(0, 32'hA5A5_0001, "R2"); expect_val(1, 1, "R2");
        hread(2'd0, 32'h1, "R10");

        // R3 write while full ignored
        hwrite(2'd1, 32'hDEAD_BEEF);
        expect_val(0, 32'hA5A5_0001, "R3"); expect_val(1, 1, "R3");

        // R5 debugger read releases
        dread();
        expect_val(1, 0, "R5");

        // R6 inbound handshake
        dwrite(32'h1111_0000);
        expect_val(2, 1, "R6");
        hread(2'd0, 32'h2, "R10");
        hread(2'd2, 32'h1111_0000, "R6");
        expect_val(2, 0, "R6"); expect_val(3, 0, "R6");

        // R4 outbound accepted with inbound flag set
        dwrite(32'h2222_0000);
        hwrite(2'd1, 32'h3333_0000);
        expect_val(1, 1, "R4"); expect_val(0, 32'h3333_0000, "R4");
        dread();

        // R7 overwrite pending inbound word
        dwrite(32'h4444_0000);
        expect_val(3, 1, "R7"); expect_val(2, 1, "R7");
        hread(2'd0, 32'h6, "R10");
        hread(2'd3, 32'h0, "R10");
        hread(2'd2, 32'h4444_0000, "R7");

        // R9 sticky: write 0 keeps, write 1 clears
        hwrite(2'd0, 32'h0);
        expect_val(3, 1, "R9");
        hwrite(2'd0, 32'h4);
        expect_val(3, 0, "R9");

        // R9 clear meets new loss: set wins
        dwrite(32'h5555_0000);
        @(negedge clk);
        dbg_rx_wr = 1; dbg_rx_word = 32'h6666_0000;
        hnd_we = 1; hnd_sel = 2'd0; hnd_wdata = 32'h4;
        idle();
        expect_val(3, 1, "R9");

        // R8 same-cycle write and read with a pending word
        @(negedge clk);
        dbg_rx_wr = 1; dbg_rx_word = 32'h7777_0000;
        hnd_re = 1; hnd_sel = 2'd2;
        #1 expect_val(4, 32'h7777_0000, "R8");
        idle();
        expect_val(2, 1, "R8"); expect_val(3, 1, "R8");

        // R8 same-cycle with empty slot: no loss, flag stays set
        hwrite(2'd0, 32'h4);
        hread(2'd2, 32'h7777_0000, "R6");
        expect_val(2, 0, "R6"); expect_val(3, 0, "R9");
        @(negedge clk);
        dbg_rx_wr = 1; dbg_rx_word = 32'h8888_0000;
        hnd_re = 1; hnd_sel = 2'd2;
        #1 expect_val(4, 32'h8888_0000, "R8");
        idle();
        expect_val(2, 1, "R8"); expect_val(3, 0, "R8");

        wait (q.size() == 0);
        #1;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule